// File: doc/BRIEF.md
# Latched Priority Interrupt Controller

This block sits next to a CPU and collects interrupt requests from 38 sources, numbered 2 to 39. Each source has a pending latch that a one-cycle pulse on its request line sets, and an enable flag. A master enable flag gates every maskable source together. Sources 2 and 3 are non-maskable. The block picks the pending, eligible source with the lowest number. It raises a request to the CPU and presents that source's index and fixed vector address.

When the CPU acknowledges, the block clears the latch of the source it was presenting and drops the master flag, so the service routine starts with maskable interrupts off. Two strobes set and clear the master flag. Software sees the latches and the enable flags through a byte-wide register window. Software can read a latch and can clear it by writing 0 to its bit. Software can never set a latch.

Top module: `irq_ctrl_top`

## Requirements
- R1: After reset every latch, every enable flag and the master flag are 0, and `irq_req` is 0.
- R2: A 1 on `src_req[n]` for n in 2..39 sets latch n in the next cycle. `src_req[0]` and `src_req[1]` have no effect, and latch bits 0 and 1 always read 0.
- R3: A register write to a latch byte clears each latch whose written bit is 0 and leaves unchanged each latch whose written bit is 1. If a hardware set and a clear hit the same latch in the same cycle, the latch ends at 1.
- R4: Software writes never clear the latches of sources 2 and 3. Only an acknowledge clears them.
- R5: A source n in 4..39 is eligible only while the master flag and enable flag n are both 1. Sources 2 and 3 are eligible whenever they are pending.
- R6: `irq_req` is 1 exactly when some pending source is eligible. `irq_idx` is then the lowest-numbered such source. Both follow the registered state combinationally.
- R7: `irq_ack` while `irq_req` is 1 clears the latch numbered `irq_idx` in the next cycle. A request on that source in the same cycle wins. `irq_ack` while `irq_req` is 0 has no effect.
- R8: `irq_vec` equals 16'hFFFC minus 4 times `irq_idx`.
- R9: Register map. Address k in 0..4 holds latch byte k, where bit j is source 8k+j. Address 5+k holds enable byte k with the same layout. Enable bytes are written directly and read back, and enable bits 0..3 read 0 and ignore writes. Other addresses read 0 and ignore writes.
- R10: `mst_set` sets the master flag and `mst_clr` clears it, with the clear winning when both are high. An accepted acknowledge clears the master flag regardless of either strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req | input | 40 | Request pulses, one bit per source number |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| mst_set | input | 1 | Master enable set strobe |
| mst_clr | input | 1 | Master enable clear strobe |
| mst_flag | output | 1 | Current master enable flag |
| irq_req | output | 1 | Interrupt request to the CPU |
| irq_idx | output | 6 | Index of the winning source |
| irq_vec | output | 16 | Vector address of the winning source |
| irq_ack | input | 1 | CPU acknowledge pulse |

## Verification
The bench targets these collisions:
- A request that arrives in the same cycle as a software clear, or as an acknowledge of the same source. A design where the clear wins would lose that request silently.
- Software clears aimed at sources 2 and 3. A design that honoured them would drop non-maskable requests.
- The master flag after acknowledge. A design that left it set would allow nested maskable service.
- An acknowledge while nothing is requested. A design that acted on it would clear an unrelated latch.

Bit 0 and bit 1 of the first byte, and the unused enable bits, are probed as well. A wrong register layout shows up as a read mismatch.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int unsigned SRC_N     = 40;
    localparam int unsigned FIRST_SRC = 2;
    localparam int unsigned NMI_LAST  = 3;
    localparam int unsigned BYTE_W    = 8;
    localparam int unsigned NUM_BYTES = SRC_N / BYTE_W;
    localparam int unsigned IDX_W     = $clog2(SRC_N);
    localparam int unsigned ADDR_W    = 4;
    localparam int unsigned VEC_W     = 16;
    localparam logic [VEC_W-1:0] VEC_TOP = 16'hFFFC;

    typedef logic [SRC_N-1:0] src_vec_t;
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank
    import irq_pkg::*;
#(
    parameter int unsigned N    = SRC_N,
    parameter int unsigned LO   = FIRST_SRC,
    parameter int unsigned NMIH = NMI_LAST
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] swclr_i,
    input  logic [N-1:0] ackclr_i,
    output logic [N-1:0] pend_o
);
    typedef struct packed {
        logic [N-1:0] pend;
    } bank_st_t;

    bank_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N; i++) begin
            if (i < LO) begin
                st_d.pend[i] = 1'b0;
            end else if (i <= NMIH) begin
                st_d.pend[i] = set_i[i] | (st_q.pend[i] & ~ackclr_i[i]);
            end else begin
                st_d.pend[i] = set_i[i] | (st_q.pend[i] & ~ackclr_i[i] & ~swclr_i[i]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.pend;
endmodule

// File: rtl/irq_regif.sv
module irq_regif
    import irq_pkg::*;
#(
    parameter int unsigned N    = SRC_N,
    parameter int unsigned BW   = BYTE_W,
    parameter int unsigned AW   = ADDR_W,
    parameter int unsigned NMIH = NMI_LAST
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_i,
    input  logic [AW-1:0] addr_i,
    input  logic [BW-1:0] wdata_i,
    input  logic [N-1:0]  pend_i,
    output logic [BW-1:0] rdata_o,
    output logic [N-1:0]  swclr_o,
    output logic [N-1:0]  en_o
);
    localparam int unsigned NB = N / BW;

    typedef struct packed {
        logic [N-1:0] en;
    } regif_st_t;

    regif_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        swclr_o = '0;
        for (int i = 0; i < N; i++) begin
            if (wr_i && addr_i == AW'(i / BW) && !wdata_i[i % BW])
                swclr_o[i] = 1'b1;
            if (i <= NMIH)
                st_d.en[i] = 1'b0;
            else if (wr_i && addr_i == AW'(NB + i / BW))
                st_d.en[i] = wdata_i[i % BW];
        end
    end

    always_comb begin
        rdata_o = '0;
        for (int b = 0; b < NB; b++) begin
            if (addr_i == AW'(b))      rdata_o = pend_i[b*BW +: BW];
            if (addr_i == AW'(NB + b)) rdata_o = st_q.en[b*BW +: BW];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_o = st_q.en;
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_pkg::*;
#(
    parameter int unsigned N    = SRC_N,
    parameter int unsigned LO   = FIRST_SRC,
    parameter int unsigned NMIH = NMI_LAST,
    parameter int unsigned IW   = IDX_W,
    parameter int unsigned VW   = VEC_W,
    parameter logic [VW-1:0] TOP = VEC_TOP
) (
    input  logic [N-1:0]  pend_i,
    input  logic [N-1:0]  en_i,
    input  logic          mst_i,
    output logic          req_o,
    output logic [IW-1:0] idx_o,
    output logic [VW-1:0] vec_o,
    output logic [N-1:0]  win_o
);
    logic [N-1:0] elig;

    always_comb begin
        elig = '0;
        for (int i = 0; i < N; i++) begin
            if (i >= LO) begin
                if (i <= NMIH) elig[i] = pend_i[i];
                else           elig[i] = pend_i[i] & en_i[i] & mst_i;
            end
        end
    end

    always_comb begin
        req_o = 1'b0;
        idx_o = '0;
        win_o = '0;
        for (int i = N - 1; i >= int'(LO); i--) begin
            if (elig[i]) begin
                req_o = 1'b1;
                idx_o = IW'(i);
            end
        end
        if (req_o) win_o[idx_o] = 1'b1;
        vec_o = TOP - (VW'(idx_o) << 2);
    end
endmodule

// File: rtl/irq_ctrl_top.sv
module irq_ctrl_top
    import irq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SRC_N-1:0]    src_req,
    input  logic                reg_wr,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [BYTE_W-1:0]   reg_wdata,
    output logic [BYTE_W-1:0]   reg_rdata,
    input  logic                mst_set,
    input  logic                mst_clr,
    output logic                mst_flag,
    output logic                irq_req,
    output logic [IDX_W-1:0]    irq_idx,
    output logic [VEC_W-1:0]    irq_vec,
    input  logic                irq_ack
);
    typedef struct packed {
        logic mst;
    } top_st_t;

    top_st_t  st_d, st_q;
    src_vec_t pend_q;
    src_vec_t en_q;
    src_vec_t swclr;
    src_vec_t win;
    src_vec_t ackclr;
    logic     accept;

    assign accept = irq_ack & irq_req;
    assign ackclr = accept ? win : '0;

    irq_pend_bank u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (src_req),
        .swclr_i  (swclr),
        .ackclr_i (ackclr),
        .pend_o   (pend_q)
    );

    irq_regif u_regif (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (reg_wr),
        .addr_i  (reg_addr),
        .wdata_i (reg_wdata),
        .pend_i  (pend_q),
        .rdata_o (reg_rdata),
        .swclr_o (swclr),
        .en_o    (en_q)
    );

    irq_arbiter u_arb (
        .pend_i (pend_q),
        .en_i   (en_q),
        .mst_i  (st_q.mst),
        .req_o  (irq_req),
        .idx_o  (irq_idx),
        .vec_o  (irq_vec),
        .win_o  (win)
    );

    always_comb begin
        st_d = st_q;
        if (mst_set) st_d.mst = 1'b1;
        if (mst_clr) st_d.mst = 1'b0;
        if (accept)  st_d.mst = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mst_flag = st_q.mst;
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk
    import irq_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [SRC_N-1:0] src_req,
    input logic [SRC_N-1:0] pend_q,
    input logic             irq_ack,
    input logic             irq_req,
    input logic [IDX_W-1:0] irq_idx,
    input logic [VEC_W-1:0] irq_vec,
    input logic             mst_flag
);
    localparam logic [SRC_N-1:0] LIVE = {{(SRC_N-FIRST_SRC){1'b1}}, {FIRST_SRC{1'b0}}};

    a_r10_ack_clears_master: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && irq_req) |=> !mst_flag);

    a_r6_idx_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_idx >= IDX_W'(FIRST_SRC) && irq_idx < IDX_W'(SRC_N)));

    a_r8_vec_of_idx: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_vec + (VEC_W'(irq_idx) << 2) == VEC_TOP));

    a_r4_nmi_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q[3] && !(irq_ack && irq_req && irq_idx == IDX_W'(3))) |=> pend_q[3]);

    a_r2_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
        ((src_req & LIVE) != '0) |=>
        ((pend_q & $past(src_req & LIVE)) == $past(src_req & LIVE)));

    a_r7_ack_clears_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && irq_req && !src_req[irq_idx]) |=> !pend_q[$past(irq_idx)]);

    a_r6_nmi_first: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q[2] |-> (irq_req && irq_idx == IDX_W'(2)));

    a_r2_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q[1:0] == 2'b00);
endmodule

bind irq_ctrl_top irq_ctrl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_req  (src_req),
    .pend_q   (pend_q),
    .irq_ack  (irq_ack),
    .irq_req  (irq_req),
    .irq_idx  (irq_idx),
    .irq_vec  (irq_vec),
    .mst_flag (mst_flag)
);

// File: tb/sim_irq_ctrl_top.sv
`timescale 1ns/1ps
module sim_irq_ctrl_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [39:0] src_req;
    logic        reg_wr;
    logic [3:0]  reg_addr;
    logic [7:0]  reg_wdata;
    logic [7:0]  reg_rdata;
    logic        mst_set, mst_clr, mst_flag;
    logic        irq_req;
    logic [5:0]  irq_idx;
    logic [15:0] irq_vec;
    logic        irq_ack;

    int checks = 0;
    int errors = 0;
    bit lat [40];
    bit en  [40];
    bit mst;

    always #5 clk = ~clk;

    irq_ctrl_top u0 (
        .clk(clk), .rst_n(rst_n), .src_req(src_req), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mst_set(mst_set), .mst_clr(mst_clr), .mst_flag(mst_flag),
        .irq_req(irq_req), .irq_idx(irq_idx), .irq_vec(irq_vec), .irq_ack(irq_ack)
    );

    function automatic int exp_win();
        for (int i = 2; i < 40; i++)
            if (lat[i] && (i < 4 || (mst && en[i]))) return i;
        return -1;
    endfunction

    function automatic logic [7:0] exp_rd(int a);
        logic [7:0] r = '0;
        if (a < 5) begin
            for (int j = 0; j < 8; j++) r[j] = lat[a*8+j];
        end else if (a < 10) begin
            for (int j = 0; j < 8; j++) r[j] = en[(a-5)*8+j];
        end
        return r;
    endfunction

    task automatic chk(string tag, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        int w = exp_win();
        chk("R6 request", irq_req, (w >= 0));
        if (w >= 0) begin
            chk("R6 index", irq_idx, w);
            chk("R8 vector", irq_vec, 16'hFFFC - 4*w);
        end
        chk("R10 master", mst_flag, mst);
        chk("R9 read data", reg_rdata, exp_rd(reg_addr));
    endtask

    task automatic model_update();
        int  w   = exp_win();
        bit  acc = irq_ack && (w >= 0);
        for (int n = 2; n < 40; n++) begin
            bit c = 0;
            if (reg_wr && reg_addr == n/8 && !reg_wdata[n%8] && n >= 4) c = 1;
            if (acc && w == n) c = 1;
            if (src_req[n])  lat[n] = 1;
            else if (c)      lat[n] = 0;
            if (n >= 4 && reg_wr && reg_addr == 5 + n/8) en[n] = reg_wdata[n%8];
        end
        if (acc)          mst = 0;
        else if (mst_clr) mst = 0;
        else if (mst_set) mst = 1;
    endtask

    task automatic idle();
        src_req = '0; reg_wr = 0; reg_addr = '0; reg_wdata = '0;
        mst_set = 0; mst_clr = 0; irq_ack = 0;
    endtask

    task automatic step();
        #1 compare_all();
        @(posedge clk);
        model_update();
        @(negedge clk);
        idle();
    endtask

    task automatic wr(int a, logic [7:0] d);
        reg_wr = 1; reg_addr = 4'(a); reg_wdata = d;
        step();
    endtask

    initial begin
        #(200000 * 10);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        idle();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        // R1: reset state
        chk("R1 request after reset", irq_req, 0);
        chk("R1 master after reset", mst_flag, 0);
        for (int a = 0; a < 10; a++) begin
            reg_addr = 4'(a); #1;
            chk("R1 register after reset", reg_rdata, 0);
        end
        @(negedge clk); idle();

        // R9/R5: enable source 10, master on, then request it
        wr(6, 8'h04);
        reg_addr = 6; #1 chk("R9 enable readback", reg_rdata, 8'h04);
        step();
        mst_set = 1; step();
        src_req[10] = 1; step();
        #1 chk("R2 latch 10 set", irq_req && irq_idx == 10, 1);
        step();

        // R6: non-maskable source 2 overtakes 10
        src_req[2] = 1; step();
        #1 chk("R6 source 2 wins", irq_idx, 2);
        step();
        // R4: software clear of source 2 and 3 ignored
        src_req[3] = 1; step();
        wr(0, 8'h00);
        reg_addr = 0; #1 chk("R4 sources 2,3 survive clear", reg_rdata, 8'h0C);
        step();
        // R7: ack clears 2 and the master flag
        irq_ack = 1; step();
        #1 chk("R7 next is source 3", irq_idx, 3);
        chk("R10 master cleared by ack", mst_flag, 0);
        step();
        irq_ack = 1; step();
        // R5: 10 pending but master off
        #1 chk("R5 masked while master off", irq_req, 0);
        step();
        // R7: ack without request has no effect
        irq_ack = 1; reg_addr = 1; step();
        reg_addr = 1; #1 chk("R7 idle ack keeps latch 10", reg_rdata, 8'h04);
        step();

        // R3: write 1 keeps, set beats clear
        wr(1, 8'hFF);
        src_req[10] = 1; reg_wr = 1; reg_addr = 1; reg_wdata = 8'h00; step();
        reg_addr = 1; #1 chk("R3 set wins over clear", reg_rdata, 8'h04);
        step();
        wr(1, 8'hFB);
        reg_addr = 1; #1 chk("R3 clear by zero", reg_rdata, 8'h00);
        step();

        // R2: bits 0 and 1 ignored
        src_req[1:0] = 2'b11; step();
        reg_addr = 0; #1 chk("R2 low bits stay zero", reg_rdata, 8'h00);
        step();
        // R9: enable bits 0..3 read zero
        wr(5, 8'hFF);
        reg_addr = 5; #1 chk("R9 low enable bits", reg_rdata, 8'hF0);
        step();
        // R10: set and clear together
        mst_set = 1; mst_clr = 1; step();
        #1 chk("R10 clear wins", mst_flag, 0);
        step();
        // R7: ack and a new request on the same source
        mst_set = 1; step();
        src_req[39] = 1; step();
        wr(9, 8'h80);
        #1 chk("R6 source 39 lone", irq_idx, 39);
        irq_ack = 1; src_req[39] = 1; step();
        reg_addr = 4; #1 chk("R7 request wins over ack", reg_rdata, 8'h80);
        step();

        // random traffic checked against the model every cycle
        for (int c = 0; c < 4000; c++) begin
            for (int n = 0; n < 40; n++) src_req[n] = ($urandom_range(0, 79) == 0);
            if ($urandom_range(0, 5) == 0) begin
                reg_wr = 1;
                reg_wdata = 8'($urandom);
            end
            reg_addr  = 4'($urandom_range(0, 11));
            mst_set   = ($urandom_range(0, 6) == 0);
            mst_clr   = ($urandom_range(0, 15) == 0);
            irq_ack   = ($urandom_range(0, 3) == 0);
            step();
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule